// File: doc/BRIEF.md
# GPIO Signal Routing Matrix

This block is a configurable crossbar between a bank of general-purpose pins and the on-chip peripherals. Each peripheral input port picks its value from any pin, from a constant high or constant low, or from a dedicated direct line that skips the matrix, with an optional inversion. Each pin picks its output value from any peripheral output signal or from its own bit of the software output register. Its output enable comes either from the selected peripheral or from the software enable register, and both the value and the enable can be inverted.

One configuration word is held per peripheral input port and one per pin. The words are written over a simple single-cycle write bus. All routing from the registered configuration to the outputs is combinational, so a written word takes effect in the cycle after the write edge. The software output and enable registers sit outside the block and arrive as plain input vectors.

Top module: `gpio_mx_top`

## Requirements
- R1: After reset every peripheral input port reads 0 whatever the pins and direct lines carry. Every pin drives its software output bit, with output enable 0.
- R2: An input word with bit 7 = 1 and select field bits [5:0] = s, where s is below the pin count, drives the port with pin s.
- R3: With bit 7 = 1, select code 0x38 drives the port high, and code 0x3C or any other code not naming a pin drives it low.
- R4: Input word bit 6 inverts the port value, on both the matrix path and the direct path.
- R5: Input word bit 7 = 0 drives the port from its own direct line, and the select field has no effect.
- R6: An output word with select field bits [7:0] = s, for s in 0 to 127, drives the pin with peripheral output s. With bit 9 = 0 the pin's enable is peripheral enable s.
- R7: Output select code 128 drives the pin with its software output bit. For this code, and for every code above it, the peripheral enable is taken as 0.
- R8: Output select codes 129 to 255 drive the pin value low before inversion.
- R9: Output word bit 8 inverts the pin value.
- R10: Output word bit 9 = 1 takes the pin enable from its software enable bit, and bit 10 inverts whichever enable was chosen.
- R11: A write changes only the addressed word. It takes effect at the clock edge that samples it and not before. A write to a pin index at or above the pin count is ignored.
- R12: Address bit 7 selects the bank (0 = peripheral input ports, 1 = pins) and bits [6:0] give the index. Input words use data bits [7:0] and pin words use bits [10:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Bank bit and word index |
| cfg_wdata | input | 11 | Configuration word |
| pin_in | input | 35 | Values sensed on the pins |
| byp_in | input | 128 | Direct line for each peripheral input port |
| periph_sig_out | input | 128 | Peripheral output signals |
| periph_sig_oe | input | 128 | Peripheral output enables |
| sw_out | input | 35 | Software output register bits |
| sw_oe | input | 35 | Software output enable register bits |
| mx_port_val | output | 128 | Values delivered to peripheral input ports |
| pad_out | output | 35 | Output value for each pin |
| pad_oe | output | 35 | Output enable for each pin |

## Verification
The bench holds every pin and direct line high across reset. A design that came out of reset in bypass mode, or with a select code naming a pin, would show a high port at once. It writes select codes just past the last pin and just past the high constant, which a decoder that tested only the low bits would route to a pin or force high. It writes output code 128 and codes above it with every peripheral enable high, which catches a design that leaks a peripheral enable or value through the non-peripheral codes. It also checks outputs during the cycle a write is presented, and after a write to an unused pin index. These catch a write path that acts early, aliases the index onto a real pin, or disturbs a neighbouring word.

// File: rtl/gpio_mx_pkg.sv
package gpio_mx_pkg;

    localparam int CFG_DW = 11;

    // input select codes that do not name a pin
    localparam logic [5:0] IN_CODE_HIGH = 6'h38;
    localparam logic [5:0] IN_CODE_LOW  = 6'h3C;

    // output select code for the software output bit
    localparam logic [7:0] OUT_CODE_SW  = 8'd128;

    typedef struct packed {
        logic       use_mx;   // 1: matrix path, 0: direct line
        logic       inv;
        logic [5:0] sel;
    } in_cfg_t;

    typedef struct packed {
        logic       oe_inv;
        logic       oe_from_sw;
        logic       inv;
        logic [7:0] sel;
    } out_cfg_t;

    localparam in_cfg_t IN_CFG_RST = '{
        use_mx: 1'b1,
        inv:    1'b0,
        sel:    IN_CODE_LOW
    };

    localparam out_cfg_t OUT_CFG_RST = '{
        oe_inv:     1'b0,
        oe_from_sw: 1'b0,
        inv:        1'b0,
        sel:        OUT_CODE_SW
    };

endpackage

// File: rtl/gpio_mx_cfg.sv
module gpio_mx_cfg
    import gpio_mx_pkg::*;
#(
    parameter int N_IN  = 128,
    parameter int N_PIN = 35,
    parameter int IDX_W = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W:0]            addr,
    input  logic [CFG_DW-1:0]         wdata,
    output in_cfg_t  [N_IN-1:0]       in_cfg,
    output out_cfg_t [N_PIN-1:0]      out_cfg
);

    localparam int IN_IW  = (N_IN  > 1) ? $clog2(N_IN)  : 1;
    localparam int PIN_IW = (N_PIN > 1) ? $clog2(N_PIN) : 1;
    localparam int IN_BITS  = $bits(in_cfg_t);
    localparam int OUT_BITS = $bits(out_cfg_t);

    typedef struct packed {
        in_cfg_t  [N_IN-1:0]  icfg;
        out_cfg_t [N_PIN-1:0] ocfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic             bank_pin;
    logic [IDX_W-1:0] idx;

    always_comb begin
        bank_pin = addr[IDX_W];
        idx      = addr[IDX_W-1:0];
        st_d     = st_q;
        if (we) begin
            if (!bank_pin) begin
                if (int'(idx) < N_IN) begin
                    st_d.icfg[idx[IN_IW-1:0]] = in_cfg_t'(wdata[IN_BITS-1:0]);
                end
            end else begin
                if (int'(idx) < N_PIN) begin
                    st_d.ocfg[idx[PIN_IW-1:0]] = out_cfg_t'(wdata[OUT_BITS-1:0]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_IN; i++) begin
                st_q.icfg[i] <= IN_CFG_RST;
            end
            for (int j = 0; j < N_PIN; j++) begin
                st_q.ocfg[j] <= OUT_CFG_RST;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign in_cfg  = st_q.icfg;
    assign out_cfg = st_q.ocfg;

endmodule

// File: rtl/gpio_mx_in_route.sv
module gpio_mx_in_route
    import gpio_mx_pkg::*;
#(
    parameter int N_IN  = 128,
    parameter int N_PIN = 35
) (
    input  in_cfg_t [N_IN-1:0]  cfg,
    input  logic [N_PIN-1:0]    pin_in,
    input  logic [N_IN-1:0]     byp_in,
    output logic [N_IN-1:0]     port_val
);

    localparam int PIN_IW = (N_PIN > 1) ? $clog2(N_PIN) : 1;

    for (genvar g = 0; g < N_IN; g++) begin : g_port
        logic mx_v;
        logic src_v;

        always_comb begin
            if (cfg[g].sel < 6'(N_PIN)) begin
                mx_v = pin_in[cfg[g].sel[PIN_IW-1:0]];
            end else if (cfg[g].sel == IN_CODE_HIGH) begin
                mx_v = 1'b1;
            end else begin
                mx_v = 1'b0;   // IN_CODE_LOW and every unused code
            end
            src_v = cfg[g].use_mx ? mx_v : byp_in[g];
        end

        assign port_val[g] = src_v ^ cfg[g].inv;
    end

endmodule

// File: rtl/gpio_mx_out_route.sv
module gpio_mx_out_route
    import gpio_mx_pkg::*;
#(
    parameter int N_PIN = 35,
    parameter int N_SIG = 128
) (
    input  out_cfg_t [N_PIN-1:0] cfg,
    input  logic [N_SIG-1:0]     sig_out,
    input  logic [N_SIG-1:0]     sig_oe,
    input  logic [N_PIN-1:0]     sw_out,
    input  logic [N_PIN-1:0]     sw_oe,
    output logic [N_PIN-1:0]     pad_out,
    output logic [N_PIN-1:0]     pad_oe
);

    localparam int SIG_IW = (N_SIG > 1) ? $clog2(N_SIG) : 1;

    for (genvar g = 0; g < N_PIN; g++) begin : g_pin
        logic val_v;
        logic per_oe_v;
        logic oe_v;

        always_comb begin
            if (cfg[g].sel < 8'(N_SIG)) begin
                val_v    = sig_out[cfg[g].sel[SIG_IW-1:0]];
                per_oe_v = sig_oe[cfg[g].sel[SIG_IW-1:0]];
            end else if (cfg[g].sel == OUT_CODE_SW) begin
                val_v    = sw_out[g];
                per_oe_v = 1'b0;
            end else begin
                val_v    = 1'b0;
                per_oe_v = 1'b0;
            end
            oe_v = cfg[g].oe_from_sw ? sw_oe[g] : per_oe_v;
        end

        assign pad_out[g] = val_v ^ cfg[g].inv;
        assign pad_oe[g]  = oe_v ^ cfg[g].oe_inv;
    end

endmodule

// File: rtl/gpio_mx_top.sv
module gpio_mx_top
    import gpio_mx_pkg::*;
#(
    parameter int N_PIN = 35,
    parameter int N_IN  = 128,
    parameter int N_SIG = 128,
    parameter int IDX_W = $clog2((N_IN > N_PIN) ? N_IN : N_PIN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W:0]      cfg_addr,
    input  logic [CFG_DW-1:0]   cfg_wdata,
    input  logic [N_PIN-1:0]    pin_in,
    input  logic [N_IN-1:0]     byp_in,
    input  logic [N_SIG-1:0]    periph_sig_out,
    input  logic [N_SIG-1:0]    periph_sig_oe,
    input  logic [N_PIN-1:0]    sw_out,
    input  logic [N_PIN-1:0]    sw_oe,
    output logic [N_IN-1:0]     mx_port_val,
    output logic [N_PIN-1:0]    pad_out,
    output logic [N_PIN-1:0]    pad_oe
);

    in_cfg_t  [N_IN-1:0]  in_cfg;
    out_cfg_t [N_PIN-1:0] out_cfg;

    gpio_mx_cfg #(
        .N_IN  (N_IN),
        .N_PIN (N_PIN),
        .IDX_W (IDX_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .in_cfg  (in_cfg),
        .out_cfg (out_cfg)
    );

    gpio_mx_in_route #(
        .N_IN  (N_IN),
        .N_PIN (N_PIN)
    ) u_in (
        .cfg      (in_cfg),
        .pin_in   (pin_in),
        .byp_in   (byp_in),
        .port_val (mx_port_val)
    );

    gpio_mx_out_route #(
        .N_PIN (N_PIN),
        .N_SIG (N_SIG)
    ) u_out (
        .cfg     (out_cfg),
        .sig_out (periph_sig_out),
        .sig_oe  (periph_sig_oe),
        .sw_out  (sw_out),
        .sw_oe   (sw_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

endmodule

// File: rtl/gpio_mx_chk.sv
module gpio_mx_chk
    import gpio_mx_pkg::*;
#(
    parameter int N_PIN = 35,
    parameter int N_IN  = 128,
    parameter int N_SIG = 128
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [N_PIN-1:0]     pin_in,
    input logic [N_IN-1:0]      byp_in,
    input logic [N_SIG-1:0]     periph_sig_out,
    input logic [N_SIG-1:0]     periph_sig_oe,
    input logic [N_PIN-1:0]     sw_out,
    input logic [N_PIN-1:0]     sw_oe,
    input logic [N_IN-1:0]      mx_port_val,
    input logic [N_PIN-1:0]     pad_out,
    input logic [N_PIN-1:0]     pad_oe,
    input in_cfg_t  [N_IN-1:0]  in_cfg,
    input out_cfg_t [N_PIN-1:0] out_cfg
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (mx_port_val == '0 && pad_oe == '0 && pad_out == sw_out));

    // R11
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_we) && $stable(pin_in) && $stable(byp_in) &&
         $stable(periph_sig_out) && $stable(periph_sig_oe) &&
         $stable(sw_out) && $stable(sw_oe))
        |-> ($stable(mx_port_val) && $stable(pad_out) && $stable(pad_oe)));

    for (genvar g = 0; g < N_IN; g++) begin : g_in_chk
        // R3
        const_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_cfg[g].use_mx && in_cfg[g].sel == IN_CODE_HIGH)
            |-> (mx_port_val[g] == !in_cfg[g].inv));

        // R5
        bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_cfg[g].use_mx |-> (mx_port_val[g] == (byp_in[g] ^ in_cfg[g].inv)));
    end

    for (genvar p = 0; p < N_PIN; p++) begin : g_pin_chk
        // R7
        sw_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_cfg[p].sel == OUT_CODE_SW)
            |-> (pad_out[p] == (sw_out[p] ^ out_cfg[p].inv)));

        // R8
        dead_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_cfg[p].sel > OUT_CODE_SW) |-> (pad_out[p] == out_cfg[p].inv));

        // R10
        sw_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_cfg[p].oe_from_sw |-> (pad_oe[p] == (sw_oe[p] ^ out_cfg[p].oe_inv)));
    end

endmodule

bind gpio_mx_top gpio_mx_chk #(
    .N_PIN (N_PIN),
    .N_IN  (N_IN),
    .N_SIG (N_SIG)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .pin_in         (pin_in),
    .byp_in         (byp_in),
    .periph_sig_out (periph_sig_out),
    .periph_sig_oe  (periph_sig_oe),
    .sw_out         (sw_out),
    .sw_oe          (sw_oe),
    .mx_port_val    (mx_port_val),
    .pad_out        (pad_out),
    .pad_oe         (pad_oe),
    .in_cfg         (in_cfg),
    .out_cfg        (out_cfg)
);

// File: tb/gpio_mx_top_test.sv
`timescale 1ns/1ps
module gpio_mx_top_test;

    localparam int NP = 35;
    localparam int NI = 128;
    localparam int NS = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [10:0]   cfg_wdata = '0;
    logic [NP-1:0] pin_in = '1;
    logic [NI-1:0] byp_in = '1;
    logic [NS-1:0] periph_sig_out = '1;
    logic [NS-1:0] periph_sig_oe = '1;
    logic [NP-1:0] sw_out = 35'h2_5555_5555;
    logic [NP-1:0] sw_oe = '1;
    logic [NI-1:0] mx_port_val;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gpio_mx_top uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_addr       (cfg_addr),
        .cfg_wdata      (cfg_wdata),
        .pin_in         (pin_in),
        .byp_in         (byp_in),
        .periph_sig_out (periph_sig_out),
        .periph_sig_oe  (periph_sig_oe),
        .sw_out         (sw_out),
        .sw_oe          (sw_oe),
        .mx_port_val    (mx_port_val),
        .pad_out        (pad_out),
        .pad_oe         (pad_oe)
    );

    // kinds: 0 = peripheral port value, 1 = pin value, 2 = pin enable
    typedef struct {
        int    kind;
        int    idx;
        logic  exp;
        string tag;
    } item_t;

    item_t sb[$];

    task automatic want(int kind, int idx, logic exp, string tag);
        item_t it;
        it.kind = kind;
        it.idx  = idx;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    // lets the monitor compare at the coming falling edge
    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int a, int d);
        cfg_we    = 1'b1;
        cfg_addr  = 8'(a);
        cfg_wdata = 11'(d);
        @(posedge clk);
        #1;
        cfg_we    = 1'b0;
    endtask

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic  act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = mx_port_val[it.idx];
                1:       act = pad_out[it.idx];
                default: act = pad_oe[it.idx];
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind %0d idx %0d: actual %b expected %b",
                         it.tag, it.kind, it.idx, act, it.exp);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state with every source high
        want(0, 0, 1'b0, "R1");
        want(0, 64, 1'b0, "R1");
        want(0, 127, 1'b0, "R1");
        want(1, 0, 1'b1, "R1");
        want(1, 1, 1'b0, "R1");
        want(2, 0, 1'b0, "R1");
        want(2, 34, 1'b0, "R1");
        settle();

        // R2: pin routing to ports
        wr(3, 'h80 | 5);
        pin_in = '0;
        pin_in[5] = 1'b1;
        want(0, 3, 1'b1, "R2");
        settle();
        pin_in = ~(35'b1 << 5);
        want(0, 3, 1'b0, "R2");
        settle();
        wr(10, 'h80 | 34);
        pin_in = '0;
        pin_in[34] = 1'b1;
        want(0, 10, 1'b1, "R2");
        want(0, 3, 1'b0, "R2");
        settle();

        // R3: constants and unused codes
        pin_in = '1;
        wr(4, 'h80 | 'h38);
        want(0, 4, 1'b1, "R3");
        settle();
        wr(4, 'h80 | 'h3C);
        want(0, 4, 1'b0, "R3");
        settle();
        wr(4, 'h80 | 35);
        want(0, 4, 1'b0, "R3");
        settle();
        wr(4, 'h80 | 'h39);
        want(0, 4, 1'b0, "R3");
        settle();
        wr(4, 'h80 | 'h3F);
        want(0, 4, 1'b0, "R3");
        settle();

        // R4: inversion on the input side
        wr(4, 'hC0 | 'h3C);
        want(0, 4, 1'b1, "R4");
        settle();
        wr(3, 'hC0 | 5);
        want(0, 3, 1'b0, "R4");
        settle();

        // R5: direct line ignores the select field
        byp_in = '0;
        wr(6, 'h38);
        want(0, 6, 1'b0, "R5");
        settle();
        byp_in[6] = 1'b1;
        want(0, 6, 1'b1, "R5");
        settle();
        wr(6, 'h40 | 'h38);
        want(0, 6, 1'b0, "R4 R5");
        settle();

        // R6: peripheral value and enable
        periph_sig_out = '0;
        periph_sig_oe  = '0;
        periph_sig_out[17] = 1'b1;
        periph_sig_oe[17]  = 1'b1;
        wr(128 + 2, 17);
        want(1, 2, 1'b1, "R6");
        want(2, 2, 1'b1, "R6");
        settle();
        periph_sig_out[17] = 1'b0;
        periph_sig_oe[17]  = 1'b0;
        want(1, 2, 1'b0, "R6");
        want(2, 2, 1'b0, "R6");
        settle();
        periph_sig_out[127] = 1'b1;
        wr(128 + 34, 127);
        want(1, 34, 1'b1, "R6");
        want(2, 34, 1'b0, "R6");
        settle();

        // R7: software output code
        periph_sig_oe = '1;
        sw_out[2] = 1'b1;
        wr(128 + 2, 128);
        want(1, 2, 1'b1, "R7");
        want(2, 2, 1'b0, "R7");
        settle();
        sw_out[2] = 1'b0;
        want(1, 2, 1'b0, "R7");
        settle();

        // R8: codes above the software code
        periph_sig_out = '1;
        sw_out = '1;
        wr(128 + 2, 200);
        want(1, 2, 1'b0, "R8");
        want(2, 2, 1'b0, "R8");
        settle();
        wr(128 + 2, 'h100 | 255);
        want(1, 2, 1'b1, "R8 R9");
        settle();

        // R9: value inversion on a peripheral
        wr(128 + 2, 'h100 | 17);
        want(1, 2, 1'b0, "R9");
        settle();
        periph_sig_out[17] = 1'b0;
        want(1, 2, 1'b1, "R9");
        settle();

        // R10: enable source and enable inversion
        sw_oe[2] = 1'b0;
        wr(128 + 2, 'h200 | 17);
        want(2, 2, 1'b0, "R10");
        settle();
        sw_oe[2] = 1'b1;
        want(2, 2, 1'b1, "R10");
        settle();
        wr(128 + 2, 'h600 | 17);
        want(2, 2, 1'b0, "R10");
        settle();
        wr(128 + 2, 'h400 | 17);
        want(2, 2, 1'b0, "R10");
        settle();
        periph_sig_oe[17] = 1'b0;
        want(2, 2, 1'b1, "R10");
        settle();

        // R11: ignored index, no effect before the edge, neighbours untouched
        wr(128 + 40, 'h7FF);
        want(1, 8, 1'b1, "R11");
        want(2, 8, 1'b0, "R11");
        want(1, 34, 1'b1, "R11");
        want(2, 2, 1'b1, "R11");
        settle();
        cfg_we    = 1'b1;
        cfg_addr  = 8'd3;
        cfg_wdata = 11'h80 | 11'h38;
        want(0, 3, 1'b0, "R11");
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        want(0, 3, 1'b1, "R11");
        want(0, 4, 1'b1, "R11");
        settle();

        // R12: the bank bit separates ports from pins
        wr(2, 'h80 | 'h38);
        want(0, 2, 1'b1, "R12");
        want(2, 2, 1'b1, "R12");
        settle();
        wr(128 + 2, 128);
        want(1, 2, 1'b1, "R12");
        want(0, 2, 1'b1, "R12");
        settle();

        settle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule